// File: doc/BRIEF.md
# Three-State Invalidation Snooping Controller

This block keeps coherence state for every line of a small direct-mapped write-back cache. Each line is Modified (the only copy, dirty), Shared (one of possibly several clean copies) or Invalid. The processor side presents one read or write at a time and holds it until the block signals completion. The bus side issues plain reads and read-exclusive requests on behalf of the processor. It also watches the same two kinds of request coming from other caches and invalidates or flushes its own copy as needed.

The bus is treated as atomic: a request issued in a cycle is complete in that cycle, so the processor access is finished together with it. Data arrays and memory timing are outside the block. It keeps only tags and states, and drives the request and flush outputs. An address splits into an index (its low `INDEX_W` bits) and a tag (the remaining upper bits).

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first processor access to any address issues a bus request.
- R2: A processor read that misses issues a bus read in the same cycle, with `bus_req_excl`=0 and `bus_req_addr` equal to the access address. It completes in that cycle and leaves the line Shared with the new tag.
- R3: A processor write that misses issues a read-exclusive request in the same cycle, with `bus_req_excl`=1. It completes in that cycle and leaves the line Modified.
- R4: A processor write that hits a Shared line issues a read-exclusive request in the same cycle. It completes at once, without waiting for data, and the line becomes Modified.
- R5: Processor reads and writes that hit a Modified line, and reads that hit a Shared line, complete in the same cycle with no bus request.
- R6: A snooped read that hits a Modified line raises `flush_valid` in the same cycle, with `flush_addr` equal to the snooped address, and the line becomes Shared. A snooped read that hits a Shared line, or that misses, changes nothing and does not flush.
- R7: A snooped read-exclusive that hits a Modified line flushes it and makes it Invalid. If it hits a Shared line, the line becomes Invalid without a flush.
- R8: A processor access that misses on a line held Modified under a different tag first spends one cycle flushing the old line. In that cycle `flush_addr` is the old tag joined with the index, there is no completion and no bus request, and the line becomes Invalid. The access is handled in a later cycle.
- R9: In any cycle with a valid snoop, the processor access neither completes nor issues a bus request. In the next cycle it is evaluated again against the state the snoop left.
- R10: While `rst_n` is low, `cpu_done`, `bus_req_valid` and `flush_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor access present, held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor access address |
| cpu_done | output | 1 | Access completes this cycle |
| bus_req_valid | output | 1 | Bus request issued this cycle |
| bus_req_excl | output | 1 | 1 = read-exclusive, 0 = read |
| bus_req_addr | output | ADDR_W | Address of the issued request |
| snp_valid | input | 1 | Request from another cache seen on the bus |
| snp_excl | input | 1 | Snooped request is read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Dirty line written out this cycle |
| flush_addr | output | ADDR_W | Address of the flushed line |

## Verification
All results are combinational on the current state and inputs: completion, bus requests and flushes appear in the same cycle as the stimulus. The new line state shows up from the next cycle onward. The bench drives inputs just after a rising edge and compares every output at the following falling edge, against a behavioural model. The model then updates its line states, as the registers do at the next rising edge. An eviction thus shows its flush in one cycle and its request in the next, and a stalled access is checked again in each cycle until it completes.

// File: rtl/msi_coh_pkg.sv
// Shared types for the three-state snooping controller.
// Assumes two state bits suffice for the Modified/Shared/Invalid encoding.
package msi_coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_state_e;

endpackage

// File: rtl/msi_line_store.sv
// Tag and state registers for every line of the direct-mapped cache.
// Two read ports (processor index, snoop index), one write port.
// Assumes at most one line update per cycle; reset makes every line Invalid.
module msi_line_store
    import msi_coh_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INDEX_W-1:0]  rd_idx_a,
    output line_state_e         rd_state_a,
    output logic [TAG_W-1:0]    rd_tag_a,
    input  logic [INDEX_W-1:0]  rd_idx_b,
    output line_state_e         rd_state_b,
    output logic [TAG_W-1:0]    rd_tag_b,
    input  logic                wr_en,
    input  logic [INDEX_W-1:0]  wr_idx,
    input  line_state_e         wr_state,
    input  logic [TAG_W-1:0]    wr_tag
);
    localparam int LINES = 1 << INDEX_W;

    line_state_e          state_q [LINES];
    logic [TAG_W-1:0]     tag_q   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line register: cleared to Invalid on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[g] <= LN_INV;
                tag_q[g]   <= '0;
            end else if (wr_en && (wr_idx == INDEX_W'(g))) begin
                state_q[g] <= wr_state;
                tag_q[g]   <= wr_tag;
            end
        end
    end

    // Read ports: plain array lookups.
    always_comb begin
        rd_state_a = state_q[rd_idx_a];
        rd_tag_a   = tag_q[rd_idx_a];
        rd_state_b = state_q[rd_idx_b];
        rd_tag_b   = tag_q[rd_idx_b];
    end

endmodule

// File: rtl/msi_snoop_ctl.sv
// Snoop response logic for one line lookup.
// Decides flush and next state for a snooped read or read-exclusive.
// Assumes the caller only applies the update when the snoop is valid.
module msi_snoop_ctl
    import msi_coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_state_e       line_state,
    input  logic [TAG_W-1:0]  line_tag,
    output logic              flush,
    output logic              upd_en,
    output line_state_e       upd_state
);
    logic hit;

    // Snoop outcome: Modified flushes, exclusive snoops invalidate.
    always_comb begin
        hit       = snp_valid && (line_state != LN_INV) && (line_tag == snp_tag);
        flush     = 1'b0;
        upd_en    = 1'b0;
        upd_state = line_state;
        if (hit) begin
            if (line_state == LN_MOD) begin
                flush     = 1'b1;
                upd_en    = 1'b1;
                upd_state = snp_excl ? LN_INV : LN_SHR;
            end else if (snp_excl) begin
                upd_en    = 1'b1;
                upd_state = LN_INV;
            end
        end
    end

endmodule

// File: rtl/msi_cpu_ctl.sv
// Processor-side decision for one line lookup.
// Chooses between silent hit, upgrade, dirty-victim eviction and miss request.
// Assumes the bus is atomic, so a request completes the access in its cycle.
module msi_cpu_ctl
    import msi_coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic              cpu_act,
    input  logic              cpu_write,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  line_state_e       line_state,
    input  logic [TAG_W-1:0]  line_tag,
    output logic              done,
    output logic              req_valid,
    output logic              req_excl,
    output logic              evict,
    output logic              upd_en,
    output line_state_e       upd_state,
    output logic [TAG_W-1:0]  upd_tag
);
    logic hit;

    // Access outcome for the current processor request.
    always_comb begin
        hit       = (line_state != LN_INV) && (line_tag == cpu_tag);
        done      = 1'b0;
        req_valid = 1'b0;
        req_excl  = 1'b0;
        evict     = 1'b0;
        upd_en    = 1'b0;
        upd_state = line_state;
        upd_tag   = line_tag;
        if (cpu_act) begin
            if (hit) begin
                done = 1'b1;
                if (cpu_write && line_state == LN_SHR) begin
                    req_valid = 1'b1;
                    req_excl  = 1'b1;
                    upd_en    = 1'b1;
                    upd_state = LN_MOD;
                end
            end else if (line_state == LN_MOD) begin
                evict     = 1'b1;
                upd_en    = 1'b1;
                upd_state = LN_INV;
            end else begin
                done      = 1'b1;
                req_valid = 1'b1;
                req_excl  = cpu_write;
                upd_en    = 1'b1;
                upd_state = cpu_write ? LN_MOD : LN_SHR;
                upd_tag   = cpu_tag;
            end
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
// Top of the three-state invalidation snooping controller.
// Combines line storage, snoop response and processor decision; a valid
// snoop takes the cycle and the processor access waits. Outputs are
// combinational on current state and inputs, and held at zero in reset.
module msi_snoop_ctrl
    import msi_coh_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic              bus_req_excl,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag;
    line_state_e        cpu_ln_state, snp_ln_state;
    logic [TAG_W-1:0]   cpu_ln_tag, snp_ln_tag;
    logic               snp_act, cpu_act;
    logic               s_flush, s_upd;
    line_state_e        s_state;
    logic               c_done, c_req, c_excl, c_evict, c_upd;
    line_state_e        c_state;
    logic [TAG_W-1:0]   c_tag;
    logic               wr_en;
    logic [INDEX_W-1:0] wr_idx;
    line_state_e        wr_state;
    logic [TAG_W-1:0]   wr_tag;

    // Address split and arbitration: snoop first, nothing while in reset.
    always_comb begin
        cpu_idx = cpu_addr[INDEX_W-1:0];
        cpu_tag = cpu_addr[ADDR_W-1:INDEX_W];
        snp_idx = snp_addr[INDEX_W-1:0];
        snp_tag = snp_addr[ADDR_W-1:INDEX_W];
        snp_act = rst_n && snp_valid;
        cpu_act = rst_n && cpu_valid && !snp_valid;
    end

    msi_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_a   (cpu_idx),
        .rd_state_a (cpu_ln_state),
        .rd_tag_a   (cpu_ln_tag),
        .rd_idx_b   (snp_idx),
        .rd_state_b (snp_ln_state),
        .rd_tag_b   (snp_ln_tag),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .wr_tag     (wr_tag)
    );

    msi_snoop_ctl #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_act),
        .snp_excl   (snp_excl),
        .snp_tag    (snp_tag),
        .line_state (snp_ln_state),
        .line_tag   (snp_ln_tag),
        .flush      (s_flush),
        .upd_en     (s_upd),
        .upd_state  (s_state)
    );

    msi_cpu_ctl #(.TAG_W(TAG_W)) u_cpu (
        .cpu_act    (cpu_act),
        .cpu_write  (cpu_write),
        .cpu_tag    (cpu_tag),
        .line_state (cpu_ln_state),
        .line_tag   (cpu_ln_tag),
        .done       (c_done),
        .req_valid  (c_req),
        .req_excl   (c_excl),
        .evict      (c_evict),
        .upd_en     (c_upd),
        .upd_state  (c_state),
        .upd_tag    (c_tag)
    );

    // Single write port: the snoop update wins, else the processor update.
    always_comb begin
        if (s_upd) begin
            wr_en    = 1'b1;
            wr_idx   = snp_idx;
            wr_state = s_state;
            wr_tag   = snp_ln_tag;
        end else begin
            wr_en    = c_upd;
            wr_idx   = cpu_idx;
            wr_state = c_state;
            wr_tag   = c_tag;
        end
    end

    // Output drive: request and flush ports.
    always_comb begin
        cpu_done      = c_done;
        bus_req_valid = c_req;
        bus_req_excl  = c_req && c_excl;
        bus_req_addr  = c_req ? cpu_addr : '0;
        flush_valid   = s_flush || c_evict;
        if (s_flush)      flush_addr = snp_addr;
        else if (c_evict) flush_addr = {cpu_ln_tag, cpu_idx};
        else              flush_addr = '0;
    end

    // A snoop cycle never completes or issues a processor access.
    assert_snoop_stalls_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (!cpu_done && !bus_req_valid));

    // Nothing is driven while reset is held.
    assert_quiet_in_reset_R10: assert property (@(posedge clk)
        !rst_n |-> (!cpu_done && !bus_req_valid && !flush_valid));

    // An eviction flush never shares its cycle with a bus request.
    assert_flush_before_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !bus_req_valid);

    // A line just taken exclusive is written again silently.
    assert_modified_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_req_valid && bus_req_excl) && cpu_valid && cpu_write &&
         !snp_valid && cpu_addr == $past(bus_req_addr))
        |-> (cpu_done && !bus_req_valid));

    // A read-snoop flush leaves the line Shared: a local read then hits.
    assert_flush_to_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_valid && snp_valid && !snp_excl) && cpu_valid && !cpu_write &&
         !snp_valid && cpu_addr == $past(snp_addr))
        |-> (cpu_done && !bus_req_valid));

    // A read-exclusive snoop hit leaves the line Invalid: a local read misses.
    assert_excl_snoop_invalidates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_valid && snp_valid && snp_excl) && cpu_valid && !cpu_write &&
         !snp_valid && cpu_addr == $past(snp_addr))
        |-> (bus_req_valid && !bus_req_excl));

endmodule

// File: tb/msi_snoop_ctrl_bench.sv
// Bench: behavioural per-line model compared with the outputs every cycle.
module msi_snoop_ctrl_bench;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          snp_valid = 1'b0, snp_excl = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          cpu_done, bus_req_valid, bus_req_excl, flush_valid;
    logic [AW-1:0] bus_req_addr, flush_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // Model: 0 = Invalid, 1 = Shared, 2 = Modified.
    int m_st  [NL];
    int m_tag [NL];
    bit m_used[NL];

    always #5 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) u_msi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_done(cpu_done),
        .bus_req_valid(bus_req_valid), .bus_req_excl(bus_req_excl),
        .bus_req_addr(bus_req_addr),
        .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
        .flush_valid(flush_valid), .flush_addr(flush_addr)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs against the model for this cycle, then advance the model.
    task automatic compare_cycle();
        int e_done = 0, e_req = 0, e_excl = 0, e_raddr = 0, e_fl = 0, e_faddr = 0;
        string rq = "R9";
        int ix, tg;
        if (!rst_n) begin
            rq = "R10";
            for (int i = 0; i < NL; i++) begin
                m_st[i] = 0; m_tag[i] = 0; m_used[i] = 0;
            end
        end else if (snp_valid) begin
            ix = int'(snp_addr) % NL;
            tg = int'(snp_addr) / NL;
            rq = snp_excl ? "R7" : "R6";
            if (cpu_valid) rq = "R9";
            if (m_st[ix] != 0 && m_tag[ix] == tg) begin
                if (m_st[ix] == 2) begin
                    e_fl = 1; e_faddr = int'(snp_addr);
                    m_st[ix] = snp_excl ? 0 : 1;
                end else if (snp_excl) begin
                    m_st[ix] = 0;
                end
            end
        end else if (cpu_valid) begin
            ix = int'(cpu_addr) % NL;
            tg = int'(cpu_addr) / NL;
            if (m_st[ix] != 0 && m_tag[ix] == tg) begin
                e_done = 1;
                if (cpu_write && m_st[ix] == 1) begin
                    rq = "R4";
                    e_req = 1; e_excl = 1; e_raddr = int'(cpu_addr);
                    m_st[ix] = 2;
                end else begin
                    rq = "R5";
                end
            end else if (m_st[ix] == 2) begin
                rq = "R8";
                e_fl = 1; e_faddr = m_tag[ix] * NL + ix;
                m_st[ix] = 0;
            end else begin
                rq = m_used[ix] ? (cpu_write ? "R3" : "R2") : "R1";
                e_done = 1; e_req = 1; e_excl = int'(cpu_write); e_raddr = int'(cpu_addr);
                m_st[ix] = cpu_write ? 2 : 1;
                m_tag[ix] = tg;
            end
            m_used[ix] = 1;
        end
        chk(rq, "cpu_done", int'(cpu_done), e_done);
        chk(rq, "bus_req_valid", int'(bus_req_valid), e_req);
        if (e_req != 0) begin
            chk(rq, "bus_req_excl", int'(bus_req_excl), e_excl);
            chk(rq, "bus_req_addr", int'(bus_req_addr), e_raddr);
        end
        chk(rq, "flush_valid", int'(flush_valid), e_fl);
        if (e_fl != 0) chk(rq, "flush_addr", int'(flush_addr), e_faddr);
    endtask

    // One clock: drive just after the rising edge, compare at the falling edge.
    task automatic step(bit cv, bit cw, int ca, bit sv, bit sx, int sa);
        @(posedge clk);
        #1;
        cpu_valid = cv; cpu_write = cw; cpu_addr = AW'(ca);
        snp_valid = sv; snp_excl = sx; snp_addr = AW'(sa);
        @(negedge clk);
        compare_cycle();
    endtask

    task automatic random_phase(int cycles);
        bit pend = 0, pw = 0;
        int pa = 0;
        for (int c = 0; c < cycles; c++) begin
            bit sv, sx;
            int sa;
            if (!pend && ($urandom_range(0, 3) != 0)) begin
                pend = 1; pw = bit'($urandom_range(0, 1)); pa = $urandom_range(0, 15);
            end
            sv = ($urandom_range(0, 9) < 3);
            sx = bit'($urandom_range(0, 1));
            sa = $urandom_range(0, 15);
            step(pend, pw, pa, sv, sx, sa);
            if (cpu_done) pend = 0;
        end
    endtask

    initial begin
        // R10 and R1: reset, then first accesses.
        step(1, 0, 'h04, 0, 0, 0);
        step(0, 0, 0, 1, 1, 'h04);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        step(1, 0, 'h04, 0, 0, 0);   // R1 read miss -> Shared
        step(1, 0, 'h04, 0, 0, 0);   // R5 read hit Shared
        step(1, 1, 'h04, 0, 0, 0);   // R4 upgrade
        step(1, 1, 'h04, 0, 0, 0);   // R5 write hit Modified
        step(0, 0, 0, 1, 0, 'h04);   // R6 flush -> Shared
        step(1, 0, 'h04, 0, 0, 0);   // R5 read hit Shared
        step(0, 0, 0, 1, 0, 'h04);   // R6 Shared read snoop: no flush
        step(0, 0, 0, 1, 1, 'h04);   // R7 Shared -> Invalid
        step(1, 0, 'h04, 0, 0, 0);   // R2 read miss again
        step(1, 1, 'h08, 0, 0, 0);   // R3 write miss (Shared victim, silent)
        step(1, 0, 'h0C, 0, 0, 0);   // R8 flush old line 0x08
        step(1, 0, 'h0C, 0, 0, 0);   // R2 request follows
        step(1, 1, 'h0D, 0, 0, 0);   // R3 write miss index 1
        step(1, 1, 'h0D, 1, 1, 'h0D);// R9 stall while snoop invalidates
        step(1, 1, 'h0D, 0, 0, 0);   // R3 re-evaluated as miss
        step(1, 0, 'h0D, 1, 0, 'h0D);// R9 stall, snoop flushes to Shared
        step(1, 0, 'h0D, 0, 0, 0);   // R5 read hit Shared
        step(0, 0, 0, 1, 1, 'h11);   // R7 snoop miss: nothing
        random_phase(3000);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        for (int a = 0; a < NL; a++) step(1, 1, a, 0, 0, 0); // R1 after reset
        random_phase(3000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule